// File: doc/BRIEF.md
# Locked Register-Memory Exchange Unit

This unit swaps a register value with the contents of one memory location, and no other access can come between the two halves of the swap. A single-cycle start pulse supplies a byte address, the value to store and a size select (full word or single byte). The unit reads the addressed location, then writes the new value to the same address, then returns the value it read. Throughout that sequence it holds a lock output. Any other master sharing the memory must stay off the bus while the lock is high.

The memory side is a simple synchronous port. It has a request, a write enable, an address, write data, per-byte lane enables, and one ready input that completes the current phase. In byte mode the two low address bits pick the lane. Only that lane is enabled and written, and the old byte comes back zero-extended. The unit takes one swap at a time and reports through a busy output while it is working.

Top module: `atomic_xchg`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy, lock, done, request and write enable are all low and the result is zero.
- R2: In the cycle after a start is accepted in the idle state, busy, lock and request are high, write enable is low, and the address equals the start address.
- R3: The read phase holds the request and address unchanged until ready is seen. The cycle after that, write enable rises with the same address, and it stays high until ready is seen again.
- R4: Lock is high in every cycle where request is high. It is low in the cycle after the write is accepted.
- R5: In word mode all four lane enables (4'b1111) are high, the write data is the full start value, and the result is the complete old word.
- R6: In byte mode only lane enable bit addr[1:0] is high. Write data bits [8k+7:8k] (k = addr[1:0]) carry bits [7:0] of the start value, and all other bits are zero. Memory outside that lane is unchanged.
- R7: In byte mode the result is the old byte from lane addr[1:0] in bits [7:0], with bits [31:8] zero.
- R8: Done is high for exactly one cycle, in the cycle after the write is accepted. Busy falls in the cycle after done.
- R9: The result changes only in the cycle where done is high, and otherwise holds its value.
- R10: A start that arrives while busy is high is ignored. It changes neither the address nor the phase in progress, and it never starts a later swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a swap |
| addr_i | input | 16 | Byte address of the location to swap |
| wdata_i | input | 32 | Register value to store |
| byte_i | input | 1 | 1 = byte swap, 0 = word swap |
| busy_o | output | 1 | Swap in progress |
| lock_o | output | 1 | Bus lock held from the read through the write |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Old memory contents |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory byte lane enables |
| mem_rdata_i | input | 32 | Memory read data, valid with ready during a read |
| mem_ready_i | input | 1 | Completes the current memory phase |

## Verification
A wrong sequencer state shows up at the ports in the cycle after the edge where it goes wrong. Request, write enable, lock, busy and done all come from that state, so a phase that is skipped, repeated or stuck breaks their expected pattern at once. A wrong lane select or a wrong captured read value can hide until done. At that point it appears in the result, or in the memory image compared at the end of the run. Random ready delays and start pulses sent during busy bring out handshake and lock-window faults.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } xchg_state_e;
endpackage

// File: rtl/xchg_lane_fmt.sv
module xchg_lane_fmt #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int LANES  = DATA_W / LANE_W,
  parameter int SEL_W  = $clog2(LANES)
) (
  input  logic              wr_byte_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_src_i,
  output logic [LANES-1:0]  wr_be_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              rd_byte_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] rd_ext_o
);
  logic [LANE_W-1:0] rd_lane;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = (wr_sel_i == SEL_W'(g));
    assign wr_be_o[g] = !wr_byte_i || hit;
    assign wr_data_o[g*LANE_W +: LANE_W] = wr_byte_i ?
      (hit ? wr_src_i[LANE_W-1:0] : '0) : wr_src_i[g*LANE_W +: LANE_W];
  end

  always_comb begin
    rd_lane = '0;
    for (int k = 0; k < LANES; k++) begin
      if (rd_sel_i == SEL_W'(k)) rd_lane = rd_data_i[k*LANE_W +: LANE_W];
    end
  end

  assign rd_ext_o = rd_byte_i ? {{(DATA_W-LANE_W){1'b0}}, rd_lane} : rd_data_i;
endmodule

// File: rtl/xchg_seq.sv
module xchg_seq
  import xchg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int SEL_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_i,
  input  logic [LANES-1:0]  fmt_be_i,
  input  logic [DATA_W-1:0] fmt_wdata_i,
  input  logic [DATA_W-1:0] rd_ext_i,
  output logic              byte_q_o,
  output logic [SEL_W-1:0]  sel_q_o,
  output logic              busy_o,
  output logic              lock_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [LANES-1:0]  mem_be_o,
  input  logic              mem_ready_i
);
  xchg_state_e       state;
  logic [DATA_W-1:0] old_q;

  assign sel_q_o = mem_addr_o[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      busy_o      <= 1'b0;
      lock_o      <= 1'b0;
      done_o      <= 1'b0;
      result_o    <= '0;
      old_q       <= '0;
      byte_q_o    <= 1'b0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_be_o    <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          state       <= ST_READ;
          busy_o      <= 1'b1;
          lock_o      <= 1'b1;
          mem_req_o   <= 1'b1;
          mem_we_o    <= 1'b0;
          mem_addr_o  <= addr_i;
          mem_be_o    <= fmt_be_i;
          mem_wdata_o <= fmt_wdata_i;
          byte_q_o    <= byte_i;
        end
        ST_READ: if (mem_ready_i) begin
          old_q    <= rd_ext_i;
          mem_we_o <= 1'b1;
          state    <= ST_WRITE;
        end
        ST_WRITE: if (mem_ready_i) begin
          mem_req_o <= 1'b0;
          mem_we_o  <= 1'b0;
          lock_o    <= 1'b0;
          done_o    <= 1'b1;
          result_o  <= old_q;
          state     <= ST_DONE;
        end
        default: begin
          busy_o <= 1'b0;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  assert_start_reads_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (mem_req_o && !mem_we_o && lock_o));
  assert_addr_held_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i) |=> $stable(mem_addr_o) && mem_req_o);
  assert_write_after_read_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_o) |-> $past(mem_req_o && mem_ready_i));
  assert_req_locked_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> lock_o);
  assert_one_lane_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && byte_q_o) |-> ($countones(mem_be_o) == 1));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!done_o && !busy_o));
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));
  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(mem_addr_o));
endmodule

// File: rtl/atomic_xchg.sv
module atomic_xchg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       byte_i,
  output logic                       busy_o,
  output logic                       lock_o,
  output logic                       done_o,
  output logic [DATA_W-1:0]          result_o,
  output logic                       mem_req_o,
  output logic                       mem_we_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic [DATA_W-1:0]          mem_wdata_o,
  output logic [DATA_W/LANE_W-1:0]   mem_be_o,
  input  logic [DATA_W-1:0]          mem_rdata_i,
  input  logic                       mem_ready_i
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int SEL_W = $clog2(LANES);

  logic [LANES-1:0]  fmt_be;
  logic [DATA_W-1:0] fmt_wdata;
  logic [DATA_W-1:0] rd_ext;
  logic              byte_q;
  logic [SEL_W-1:0]  sel_q;

  xchg_lane_fmt #(
    .DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES), .SEL_W(SEL_W)
  ) u_fmt (
    .wr_byte_i (byte_i),
    .wr_sel_i  (addr_i[SEL_W-1:0]),
    .wr_src_i  (wdata_i),
    .wr_be_o   (fmt_be),
    .wr_data_o (fmt_wdata),
    .rd_byte_i (byte_q),
    .rd_sel_i  (sel_q),
    .rd_data_i (mem_rdata_i),
    .rd_ext_o  (rd_ext)
  );

  xchg_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .SEL_W(SEL_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .addr_i      (addr_i),
    .byte_i      (byte_i),
    .fmt_be_i    (fmt_be),
    .fmt_wdata_i (fmt_wdata),
    .rd_ext_i    (rd_ext),
    .byte_q_o    (byte_q),
    .sel_q_o     (sel_q),
    .busy_o      (busy_o),
    .lock_o      (lock_o),
    .done_o      (done_o),
    .result_o    (result_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_be_o    (mem_be_o),
    .mem_ready_i (mem_ready_i)
  );
endmodule

// File: tb/atomic_xchg_tb.sv
module atomic_xchg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        byte_i = 1'b0;
  logic        busy_o, lock_o, done_o, mem_req_o, mem_we_o;
  logic [31:0] result_o, mem_wdata_o, mem_rdata_i;
  logic [15:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic        mem_ready_i = 1'b0;

  logic [31:0] mem     [64];
  logic [31:0] exp_mem [64];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  int          ph = 0;
  logic [15:0] ma = '0;
  logic [31:0] md = '0;
  logic        mb = 1'b0;
  logic [31:0] mold = '0;
  logic [31:0] mres = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_xchg u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .byte_i(byte_i), .busy_o(busy_o), .lock_o(lock_o), .done_o(done_o),
    .result_o(result_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o),
    .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i)
  );

  assign mem_rdata_i = mem[mem_addr_o[7:2]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // memory model
  always @(posedge clk) begin
    if (mem_req_o && mem_we_o && mem_ready_i) begin
      for (int k = 0; k < 4; k++)
        if (mem_be_o[k]) mem[mem_addr_o[7:2]][k*8 +: 8] <= mem_wdata_o[k*8 +: 8];
    end
  end

  // ready with random wait states
  always @(negedge clk) mem_ready_i = mem_req_o && (($urandom % 3) != 0);

  // behavioural reference model
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      ph = 0; mres = '0;
    end else begin
      case (ph)
        0: if (start_i) begin ph = 1; ma = addr_i; md = wdata_i; mb = byte_i; end
        1: if (mem_ready_i) begin
             mold = exp_mem[ma[7:2]];
             if (mb) mold = (mold >> (8 * ma[1:0])) & 32'hFF;
             ph = 2;
           end
        2: if (mem_ready_i) begin
             if (mb) exp_mem[ma[7:2]][8*ma[1:0] +: 8] = md[7:0];
             else    exp_mem[ma[7:2]] = md;
             mres = mold; ph = 3;
           end
        default: ph = 0;
      endcase
    end
  end

  // cycle compare
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R8 R10 busy", 32'(busy_o), 32'(ph != 0));
      chk("R4 lock", 32'(lock_o), 32'(ph == 1 || ph == 2));
      chk("R2 R3 req", 32'(mem_req_o), 32'(ph == 1 || ph == 2));
      chk("R3 we", 32'(mem_we_o), 32'(ph == 2));
      chk("R8 done", 32'(done_o), 32'(ph == 3));
      chk(mb ? "R7 R9 result" : "R5 R9 result", result_o, mres);
      if (ph == 1 || ph == 2) begin
        chk("R2 R10 addr", 32'(mem_addr_o), 32'(ma));
        chk(mb ? "R6 be" : "R5 be", 32'(mem_be_o), mb ? 32'(4'b0001 << ma[1:0]) : 32'hF);
      end
      if (ph == 2)
        chk(mb ? "R6 wdata" : "R5 wdata", mem_wdata_o,
            mb ? (32'(md[7:0]) << (8 * ma[1:0])) : md);
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic do_op(input logic [15:0] a, input logic [31:0] d, input logic b, input bit poke);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    start_i = 1'b1; addr_i = a; wdata_i = d; byte_i = b;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      start_i = 1'b1; addr_i = a ^ 16'h0044; wdata_i = ~d; byte_i = ~b;  // R10 busy start
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'h01020304 * (i + 1) ^ 32'hA55A0FF0;
      exp_mem[i] = mem[i];
    end
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 lock", 32'(lock_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 req", 32'(mem_req_o), 0);
    chk("R1 we", 32'(mem_we_o), 0);
    chk("R1 result", result_o, 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    do_op(16'h0010, 32'hDEADBEEF, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) do_op(16'h0020 + 16'(k), 32'h1234_56C0 + 32'(k), 1'b1, 1'b0);
    do_op(16'h0024, 32'hCAFEF00D, 1'b0, 1'b1);
    do_op(16'h0033, 32'h0000_0081, 1'b1, 1'b1);
    do_op(16'h0010, 32'h0BADF00D, 1'b0, 1'b0);
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      start_i = (($urandom % 4) == 0);
      addr_i  = 16'($urandom % 256);
      wdata_i = $urandom;
      byte_i  = $urandom % 2;
    end
    @(negedge clk);
    start_i = 1'b0;
    repeat (40) @(negedge clk);
    for (int i = 0; i < 64; i++) chk("R5 R6 memory", mem[i], exp_mem[i]);
    finish_run();
  end
endmodule